// File: doc/BRIEF.md
# Program-Order Store Buffer

This block holds stores that have not yet committed, in program order, between decode and the data memory. A store takes a slot when it is decoded and gets a tag back. It then receives its address and its data through two separate update ports, in either order and at any time. A commit strobe tells the buffer that the oldest store still waiting to commit is now the oldest instruction in the machine. Committed stores leave for memory one at a time, through a valid/ready write port. Until that point memory is untouched, so discarding a store costs no memory undo.

A flush names a store tag. Every uncommitted store younger than that tag is dropped, and stores that have already committed always stay. Loads search the buffer, from the youngest store older than the load downwards. The first store that has an unknown address, or the same address as the load, decides the answer. The load gets that store's data, or it is told to stall, or it is told that no older store in the buffer affects it.

Top module: `store_order_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o`=1, `alloc_tag_o`=0, `mem_valid_o`=0.
- R2: Tags are handed out in allocation order. A tag is the running allocation count modulo 2·DEPTH. Slot index = tag modulo DEPTH. A store's age = (tag − oldest held tag) modulo 2·DEPTH.
- R3: Allocation is refused while DEPTH stores are held, even if one drains in the same cycle. It is also refused in any cycle with `flush_i` high.
- R4: The address and the data are each written only if the tag names a store that is held and not yet committed. An update to any other tag is ignored.
- R5: `commit_i` commits the oldest uncommitted store only when that store already holds both its address and its data. Otherwise `commit_i` has no effect.
- R6: Committed stores are presented on the memory port oldest first. The port drains at most one store per cycle. Its address and data stay stable while `mem_ready_i` is low.
- R7: A flush keeps every store up to and including the flush tag, plus every committed store, and discards the rest. A commit in the same cycle is applied before the flush. A flush tag that is not held has no effect.
- R8: The stores older than a load are those whose age is below the age of `ld_limit_i`. If the youngest older store that has either an unknown address or the same address has both fields known and the same address, `ld_hit_o`=1 and `ld_data_o` is that store's data.
- R9: If that deciding store has an unknown address, or has the same address but no data, `ld_stall_o`=1.
- R10: If no older store decides, both flags are 0. This also holds when the age of `ld_limit_i` exceeds the number of held stores, i.e. the load is older than every held store.
- R11: `ld_hit_o` and `ld_stall_o` are never high together, and both are 0 when `ld_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Decode requests a slot |
| alloc_ready_o | output | 1 | A slot can be taken this cycle |
| alloc_tag_o | output | PW | Tag given to the allocating store |
| upd_addr_valid_i | input | 1 | Address update strobe |
| upd_addr_tag_i | input | PW | Tag of the store receiving the address |
| upd_addr_i | input | AW | Store address |
| upd_data_valid_i | input | 1 | Data update strobe |
| upd_data_tag_i | input | PW | Tag of the store receiving the data |
| upd_data_i | input | DW | Store data |
| commit_i | input | 1 | Oldest uncommitted store is now oldest in the machine |
| flush_i | input | 1 | Discard stores younger than the flush tag |
| flush_tag_i | input | PW | Youngest store to keep |
| ld_valid_i | input | 1 | Load lookup request |
| ld_addr_i | input | AW | Load address |
| ld_limit_i | input | PW | Tag the next store would get at the load's decode |
| ld_hit_o | output | 1 | Forwarded data is valid |
| ld_stall_o | output | 1 | Load must wait |
| ld_data_o | output | DW | Forwarded data |
| mem_valid_o | output | 1 | Committed store offered to memory |
| mem_ready_i | input | 1 | Memory accepts the store |
| mem_addr_o | output | AW | Write address |
| mem_data_o | output | DW | Write data |

## Verification
The risky overlaps are a commit and a flush in the same cycle, and a drain in the same cycle as an allocation into a full buffer. A directed step raises `commit_i` and `flush_i` together with a flush tag older than the committing store. The following `alloc_tag_o` must then show that the committed store survived. The random phase mixes all strobes every cycle. Each cycle the bench model, which applies commit before flush, predicts `alloc_ready_o`, the tag, the memory port and the load answer.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [1:0] {
    LD_MISS  = 2'd0,
    LD_HIT   = 2'd1,
    LD_STALL = 2'd2
  } ld_res_e;
endpackage

// File: rtl/sob_ptr_ctrl.sv
module sob_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_valid_i,
  input  logic          commit_i,
  input  logic          cmt_ok_i,
  input  logic          flush_i,
  input  logic [PW-1:0] flush_tag_i,
  input  logic          mem_ready_i,
  output logic          alloc_ready_o,
  output logic          alloc_fire_o,
  output logic          cmt_fire_o,
  output logic          drain_fire_o,
  output logic [PW-1:0] head_o,
  output logic [PW-1:0] cmt_o,
  output logic [PW-1:0] tail_o,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] ccnt_o
);
  logic [PW-1:0] head_q, cmt_q, tail_q;
  logic [PW-1:0] cnt, ccnt, f_age, keep, cage_n, tail_n;
  logic          flush_hit;

  always_comb begin
    cnt           = tail_q - head_q;
    ccnt          = cmt_q - head_q;
    alloc_ready_o = (cnt != PW'(DEPTH)) && !flush_i;
    alloc_fire_o  = alloc_valid_i && alloc_ready_o;
    cmt_fire_o    = commit_i && (ccnt != cnt) && cmt_ok_i;
    drain_fire_o  = (ccnt != '0) && mem_ready_i;
    f_age         = flush_tag_i - head_q;
    flush_hit     = flush_i && (f_age < cnt);
    keep          = f_age + PW'(1);
    cage_n        = ccnt + PW'(cmt_fire_o);
    // commit applied first, committed stores are never cut
    if (flush_hit) tail_n = head_q + ((keep > cage_n) ? keep : cage_n);
    else           tail_n = tail_q + PW'(alloc_fire_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + PW'(drain_fire_o);
      cmt_q  <= cmt_q + PW'(cmt_fire_o);
      tail_q <= tail_n;
    end
  end

  assign head_o = head_q;
  assign cmt_o  = cmt_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt;
  assign ccnt_o = ccnt;
endmodule

// File: rtl/sob_entries.sv
module sob_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [IW-1:0]    alloc_idx_i,
  input  logic             ua_en_i,
  input  logic [IW-1:0]    ua_idx_i,
  input  logic [AW-1:0]    ua_addr_i,
  input  logic             ud_en_i,
  input  logic [IW-1:0]    ud_idx_i,
  input  logic [DW-1:0]    ud_data_i,
  output logic [DEPTH-1:0] av_o,
  output logic [DEPTH-1:0] dv_o,
  output logic [AW-1:0]    addr_o [DEPTH],
  output logic [DW-1:0]    data_o [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        av_o[g]   <= 1'b0;
        dv_o[g]   <= 1'b0;
        addr_o[g] <= '0;
        data_o[g] <= '0;
      end else if (alloc_i && alloc_idx_i == IW'(g)) begin
        av_o[g] <= 1'b0;
        dv_o[g] <= 1'b0;
      end else begin
        if (ua_en_i && ua_idx_i == IW'(g)) begin
          av_o[g]   <= 1'b1;
          addr_o[g] <= ua_addr_i;
        end
        if (ud_en_i && ud_idx_i == IW'(g)) begin
          dv_o[g]   <= 1'b1;
          data_o[g] <= ud_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/sob_fwd.sv
module sob_fwd
  import sob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 4,
  parameter int IW    = 3
) (
  input  logic             ld_valid_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [PW-1:0]    ld_limit_i,
  input  logic [PW-1:0]    head_i,
  input  logic [PW-1:0]    cnt_i,
  input  logic [DEPTH-1:0] av_i,
  input  logic [DEPTH-1:0] dv_i,
  input  logic [AW-1:0]    addr_i [DEPTH],
  input  logic [DW-1:0]    data_i [DEPTH],
  output logic             hit_o,
  output logic             stall_o,
  output logic [DW-1:0]    data_o
);
  logic [PW-1:0] lim_age, lim;
  logic [IW-1:0] idx, sel;
  logic          found;
  ld_res_e       res;

  always_comb begin
    lim_age = ld_limit_i - head_i;
    lim     = (lim_age > cnt_i) ? '0 : lim_age;  // load older than all held stores
    found   = 1'b0;
    sel     = '0;
    idx     = '0;
    // later iterations are younger and override
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_i[IW-1:0] + IW'(i);
      if (PW'(i) < lim && (!av_i[idx] || addr_i[idx] == ld_addr_i)) begin
        found = 1'b1;
        sel   = idx;
      end
    end
    if (!ld_valid_i || !found)     res = LD_MISS;
    else if (av_i[sel] && dv_i[sel]) res = LD_HIT;
    else                           res = LD_STALL;
    hit_o   = (res == LD_HIT);
    stall_o = (res == LD_STALL);
    data_o  = hit_o ? data_i[sel] : '0;
  end
endmodule

// File: rtl/store_order_buf.sv
module store_order_buf #(
  parameter int  DEPTH = 8,
  parameter int  AW    = 32,
  parameter int  DW    = 32,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_valid_i,
  output logic          alloc_ready_o,
  output logic [PW-1:0] alloc_tag_o,
  input  logic          upd_addr_valid_i,
  input  logic [PW-1:0] upd_addr_tag_i,
  input  logic [AW-1:0] upd_addr_i,
  input  logic          upd_data_valid_i,
  input  logic [PW-1:0] upd_data_tag_i,
  input  logic [DW-1:0] upd_data_i,
  input  logic          commit_i,
  input  logic          flush_i,
  input  logic [PW-1:0] flush_tag_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [PW-1:0] ld_limit_i,
  output logic          ld_hit_o,
  output logic          ld_stall_o,
  output logic [DW-1:0] ld_data_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o
);
  logic [PW-1:0]    head, cmt, tail, cnt, ccnt, ua_age, ud_age;
  logic             alloc_fire, cmt_fire, drain_fire, cmt_ok, ua_ok, ud_ok;
  logic [DEPTH-1:0] av, dv;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];

  assign cmt_ok = av[cmt[IW-1:0]] && dv[cmt[IW-1:0]];

  sob_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW)) i_ptr (
    .clk_i, .rst_ni,
    .alloc_valid_i, .commit_i, .cmt_ok_i(cmt_ok),
    .flush_i, .flush_tag_i, .mem_ready_i,
    .alloc_ready_o, .alloc_fire_o(alloc_fire),
    .cmt_fire_o(cmt_fire), .drain_fire_o(drain_fire),
    .head_o(head), .cmt_o(cmt), .tail_o(tail),
    .cnt_o(cnt), .ccnt_o(ccnt)
  );

  // updates land only on held, uncommitted stores
  assign ua_age = upd_addr_tag_i - head;
  assign ud_age = upd_data_tag_i - head;
  assign ua_ok  = upd_addr_valid_i && ua_age >= ccnt && ua_age < cnt;
  assign ud_ok  = upd_data_valid_i && ud_age >= ccnt && ud_age < cnt;

  sob_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW)) i_ent (
    .clk_i, .rst_ni,
    .alloc_i(alloc_fire), .alloc_idx_i(tail[IW-1:0]),
    .ua_en_i(ua_ok), .ua_idx_i(upd_addr_tag_i[IW-1:0]), .ua_addr_i(upd_addr_i),
    .ud_en_i(ud_ok), .ud_idx_i(upd_data_tag_i[IW-1:0]), .ud_data_i(upd_data_i),
    .av_o(av), .dv_o(dv), .addr_o(addr_q), .data_o(data_q)
  );

  sob_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW), .IW(IW)) i_fwd (
    .ld_valid_i, .ld_addr_i, .ld_limit_i,
    .head_i(head), .cnt_i(cnt),
    .av_i(av), .dv_i(dv), .addr_i(addr_q), .data_i(data_q),
    .hit_o(ld_hit_o), .stall_o(ld_stall_o), .data_o(ld_data_o)
  );

  assign alloc_tag_o = tail;
  assign mem_valid_o = (ccnt != '0);
  assign mem_addr_o  = addr_q[head[IW-1:0]];
  assign mem_data_o  = data_q[head[IW-1:0]];
endmodule

// File: rtl/sob_checker.sv
module sob_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          ld_hit_o,
  input logic          ld_stall_o,
  input logic [PW-1:0] head_i,
  input logic [PW-1:0] cmt_i,
  input logic [PW-1:0] tail_i
);
  logic [PW-1:0] occ, cocc;
  assign occ  = tail_i - head_i;
  assign cocc = cmt_i - head_i;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PW'(DEPTH));

  p_commit_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cocc <= occ);

  p_mem_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  p_drain_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> head_i == $past(head_i) + PW'(1));

  p_flush_keeps_cmt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ready_i |=> (cmt_i - head_i) >= $past(cmt_i - head_i));

  p_hit_stall_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_hit_o && ld_stall_o));
endmodule

bind store_order_buf sob_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
  .ld_hit_o(ld_hit_o), .ld_stall_o(ld_stall_o),
  .head_i(head), .cmt_i(cmt), .tail_i(tail)
);

// File: tb/test_store_order_buf.sv
`timescale 1ns/1ps
module test_store_order_buf;
  localparam int D  = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int PW = 4;
  localparam int T2 = 2 * D;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic alloc_valid_i, alloc_ready_o;
  logic [PW-1:0] alloc_tag_o;
  logic upd_addr_valid_i, upd_data_valid_i, commit_i, flush_i, ld_valid_i, mem_ready_i;
  logic [PW-1:0] upd_addr_tag_i, upd_data_tag_i, flush_tag_i, ld_limit_i;
  logic [AW-1:0] upd_addr_i, ld_addr_i, mem_addr_o;
  logic [DW-1:0] upd_data_i, ld_data_o, mem_data_o;
  logic ld_hit_o, ld_stall_o, mem_valid_o;

  always #2.5 clk_i = ~clk_i;

  store_order_buf #(.DEPTH(D), .AW(AW), .DW(DW)) i_store_order_buf (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  int h = 0, c = 0, t = 0;
  logic [AW-1:0] ma [D];
  logic [DW-1:0] md [D];
  bit mav [D], mdv [D];
  logic [AW-1:0] pool [4] = '{32'h100, 32'h204, 32'h100 + 32'h40, 32'h3fc};

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ag(logic [PW-1:0] tag);
    return (int'(tag) - (h % T2) + T2) % T2;
  endfunction

  task automatic idle();
    alloc_valid_i = 0; upd_addr_valid_i = 0; upd_data_valid_i = 0;
    upd_addr_tag_i = '0; upd_data_tag_i = '0; upd_addr_i = '0; upd_data_i = '0;
    commit_i = 0; flush_i = 0; flush_tag_i = '0;
    ld_valid_i = 0; ld_addr_i = '0; ld_limit_i = '0; mem_ready_i = 0;
  endtask

  // check outputs against model, then advance one clock and update model
  task automatic step();
    int cnt, ccnt, la, lim, fa;
    bit ehit, est, cf, df, af, fh;
    logic [DW-1:0] ed;
    #1;
    cnt = t - h; ccnt = c - h;
    chk(alloc_ready_o == (cnt < D && !flush_i), "R3 alloc_ready", alloc_ready_o, (cnt < D && !flush_i));
    chk(alloc_tag_o == PW'(t % T2), "R2 alloc_tag", alloc_tag_o, t % T2);
    chk(mem_valid_o == (c > h), "R6 mem_valid", mem_valid_o, c > h);
    if (c > h)
      chk(mem_addr_o == ma[h % D] && mem_data_o == md[h % D], "R6 mem_write",
          {mem_addr_o, mem_data_o}, {ma[h % D], md[h % D]});
    ehit = 0; est = 0; ed = '0;
    if (ld_valid_i) begin
      la = ag(ld_limit_i);
      lim = (la > cnt) ? 0 : la;
      for (int i = lim - 1; i >= 0; i--) begin
        int ix = (h + i) % D;
        if (!mav[ix]) begin est = 1; break; end
        if (ma[ix] == ld_addr_i) begin
          if (mdv[ix]) begin ehit = 1; ed = md[ix]; end else est = 1;
          break;
        end
      end
    end
    if (ehit) chk(ld_hit_o && !ld_stall_o && ld_data_o == ed, "R8 forward", {ld_hit_o, ld_stall_o, ld_data_o}, {1'b1, 1'b0, ed});
    else if (est) chk(!ld_hit_o && ld_stall_o, "R9 stall", {ld_hit_o, ld_stall_o}, 2'b01);
    else chk(!ld_hit_o && !ld_stall_o, "R10 miss", {ld_hit_o, ld_stall_o}, 2'b00);
    @(posedge clk_i);
    cf = commit_i && c < t && mav[c % D] && mdv[c % D];
    df = (c > h) && mem_ready_i;
    af = alloc_valid_i && cnt < D && !flush_i;
    fa = ag(flush_tag_i);
    fh = flush_i && fa < cnt;
    if (upd_addr_valid_i && ag(upd_addr_tag_i) >= ccnt && ag(upd_addr_tag_i) < cnt) begin
      mav[upd_addr_tag_i % D] = 1; ma[upd_addr_tag_i % D] = upd_addr_i;
    end
    if (upd_data_valid_i && ag(upd_data_tag_i) >= ccnt && ag(upd_data_tag_i) < cnt) begin
      mdv[upd_data_tag_i % D] = 1; md[upd_data_tag_i % D] = upd_data_i;
    end
    c = c + int'(cf);
    if (fh) t = h + (((fa + 1) > (c - h)) ? (fa + 1) : (c - h));
    else if (af) begin mav[t % D] = 0; mdv[t % D] = 0; t++; end
    h = h + int'(df);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < D; i++) begin ma[i] = '0; md[i] = '0; mav[i] = 0; mdv[i] = 0; end
    idle();
    repeat (3) @(posedge clk_i);
    #1;
    chk(alloc_ready_o && alloc_tag_o == 0 && !mem_valid_o, "R1 reset", {alloc_ready_o, alloc_tag_o, mem_valid_o}, {1'b1, 4'd0, 1'b0});
    @(negedge clk_i); rst_ni = 1;

    // fill to full, ninth request refused
    for (int k = 0; k < D + 1; k++) begin
      @(negedge clk_i); idle(); alloc_valid_i = 1; step();
    end
    @(negedge clk_i); idle(); #1;
    chk(!alloc_ready_o && t - h == D, "R3 full", alloc_ready_o, 0);

    // commit with incomplete oldest store ignored
    @(negedge clk_i); idle(); commit_i = 1; step();
    @(negedge clk_i); idle(); #1;
    chk(!mem_valid_o, "R5 commit ignored", mem_valid_o, 0);
    step();

    // address/data for tag 0, data only for tag 1
    @(negedge clk_i); idle();
    upd_addr_valid_i = 1; upd_addr_tag_i = 0; upd_addr_i = pool[0];
    upd_data_valid_i = 1; upd_data_tag_i = 1; upd_data_i = 32'hbeef;
    step();
    @(negedge clk_i); idle(); upd_data_valid_i = 1; upd_data_tag_i = 0; upd_data_i = 32'hcafe; step();
    @(negedge clk_i); idle(); ld_valid_i = 1; ld_addr_i = pool[0]; ld_limit_i = 2; #1;
    chk(ld_stall_o && !ld_hit_o, "R9 unknown addr", {ld_hit_o, ld_stall_o}, 2'b01);
    step();
    @(negedge clk_i); idle(); ld_valid_i = 1; ld_addr_i = pool[0]; ld_limit_i = 1; #1;
    chk(ld_hit_o && ld_data_o == 32'hcafe, "R8 hit", ld_data_o, 32'hcafe);
    step();

    // commit tag 0, memory held off; then update to committed store ignored
    @(negedge clk_i); idle(); commit_i = 1; step();
    @(negedge clk_i); idle(); upd_data_valid_i = 1; upd_data_tag_i = 0; upd_data_i = 32'h1111; step();
    @(negedge clk_i); idle(); #1;
    chk(mem_valid_o && mem_data_o == 32'hcafe, "R4 committed update ignored", mem_data_o, 32'hcafe);
    step();

    // commit tag 1 and flush to tag 0 in the same cycle
    @(negedge clk_i); idle(); upd_addr_valid_i = 1; upd_addr_tag_i = 1; upd_addr_i = pool[1]; step();
    @(negedge clk_i); idle(); commit_i = 1; flush_i = 1; flush_tag_i = 0; step();
    @(negedge clk_i); idle(); #1;
    chk(alloc_tag_o == 2, "R7 commit before flush", alloc_tag_o, 2);
    step();
    // flush with a tag not held
    @(negedge clk_i); idle(); flush_i = 1; flush_tag_i = 9; step();
    @(negedge clk_i); idle(); #1;
    chk(alloc_tag_o == 2, "R7 unheld tag", alloc_tag_o, 2);
    chk(!ld_hit_o && !ld_stall_o, "R11 idle load", {ld_hit_o, ld_stall_o}, 0);
    step();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int cnt;
      @(negedge clk_i); idle();
      cnt = t - h;
      alloc_valid_i    = ($urandom_range(0, 1) == 1);
      upd_addr_valid_i = ($urandom_range(0, 1) == 1);
      upd_addr_tag_i   = PW'((h + $urandom_range(0, D)) % T2);
      upd_addr_i       = pool[$urandom_range(0, 3)];
      upd_data_valid_i = ($urandom_range(0, 1) == 1);
      upd_data_tag_i   = PW'((h + $urandom_range(0, D)) % T2);
      upd_data_i       = $urandom;
      commit_i         = ($urandom_range(0, 9) < 4);
      flush_i          = ($urandom_range(0, 19) == 0);
      flush_tag_i      = PW'((h + $urandom_range(0, D)) % T2);
      ld_valid_i       = ($urandom_range(0, 9) < 7);
      ld_addr_i        = pool[$urandom_range(0, 3)];
      if ($urandom_range(0, 9) == 0) ld_limit_i = PW'((h + T2 - 1) % T2);
      else ld_limit_i = PW'((h + $urandom_range(0, cnt)) % T2);
      mem_ready_i      = ($urandom_range(0, 9) < 6);
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule